// File: doc/BRIEF.md
# Floppy Disk Controller Register Front End

This block sits on a byte-wide host bus and gives software four registers: a command register that reads back as a status word, a track register, a sector register and a data register. Writing a command starts a fixed timing sequence. A preparation phase runs first, then an execution phase, and the block then drops back to idle. The status word shows which phase the block is in and whether a byte transfer is pending.

For sector commands, the block turns the track, the external side-select input and the sector number into a linear byte address. The geometry is fixed: 2 sides, 9 sectors per track, 512 bytes per sector, and sectors are numbered from 1. Data-register accesses then stream bytes to or from a simple synchronous memory port. Each byte moved restarts the execution timer, so a transfer stays alive for as long as the host keeps up.

The meaning of a data-register write depends on the phase. During execution of a write-sector command it stores a byte. At any other time it latches the target track for a later seek.

Top module: `floppy_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the track, sector, data and command registers, the track-zero flag and the error flag, and leaves the block idle. Status then reads 0x80, and the track and sector registers read 0.
- R2: The status word is formed as follows. Bit 7 is always 1. Bit 0 (busy) is 1 only in the execution phase. Bit 1 (transfer request) is 1 only in the execution phase of a read-sector (0x80, 0x90) or write-sector (0xA0, 0xA2) command. Bit 2 is the track-zero flag. All other bits are 0.
- R3: Writing any command at offset 0 starts a preparation phase of LAT (10) clocks. An execution phase of EXE (10) clocks follows, after which the block returns to idle.
- R4: Command 0x00 (restore) sets the track register to 0 and sets the track-zero flag.
- R5: Commands 0x10 and 0x14 (seek) copy the data register into the track register. They set the track-zero flag exactly when the new track is 0.
- R6: Sector commands set the byte pointer to ((track*2 + side)*9 + sector - 1)*512, taken modulo 2^20, and clear the track-zero flag. The pointer drives `mem_addr` during every transfer.
- R7: In the execution phase of a read-sector command, a read at offset 3 asserts `mem_re` and returns `mem_rdata`. It also advances the pointer by one and reloads the execution timer to EXE, even when the read lands on the final execution clock.
- R8: In the execution phase of a write-sector command, a write at offset 3 asserts `mem_we` with the byte on `mem_wdata`, advances the pointer and reloads the execution timer. A write at offset 3 in any other situation only latches the data register and leaves the memory port untouched.
- R9: Command 0xD0 (force interrupt) returns the block to idle on the next clock and clears the current command and the track-zero flag.
- R10: Command 0xF0 (write track) sets the sticky error flag and never asserts `mem_we` or `mem_re`.
- R11: A read at offset 3 outside the execution phase of a read-sector command returns 0 and sets the sticky error flag. Only reset clears that flag.
- R12: Writes at offsets 1 and 2 load the track and sector registers, and reads at those offsets return them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset (0 command/status, 1 track, 2 sector, 3 data) |
| bus_wdata | input | 8 | Write data from host |
| bus_rdata | output | 8 | Read data to host (combinational) |
| side | input | 1 | Side select from outside |
| mem_addr | output | AW | Byte address to backing store |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | Store strobe |
| mem_re | output | 1 | Fetch strobe |
| mem_rdata | input | 8 | Fetched byte, combinational from mem_addr |
| err | output | 1 | Sticky error flag |

## Verification
The hardest situation to reach from the ports is a transfer that arrives on the very clock where the execution timer would expire. That transfer must win, and the block must stay busy for another full window. The stimulus reaches it by counting clocks from the command write and reading the data register exactly nine idle cycles into execution. A cycle-level reference model predicts the status word on every clock, so a wrong phase length or a lost reload shows up at once. Data-register accesses during the preparation phase and during the wrong command's execution are also driven, to separate the latch, store and error paths.

// File: rtl/floppy_ctrl.sv
module floppy_ctrl #(
  parameter int AW        = 20,
  parameter int SIDES     = 2,
  parameter int SECS      = 9,
  parameter int SEC_BYTES = 512,
  parameter int LAT       = 10,
  parameter int EXE       = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          side,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [7:0]    mem_rdata,
  output logic          err
);
  localparam int CW = $clog2((LAT > EXE ? LAT : EXE) + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_PREP, PH_EXEC} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [7:0]    cmd, trk, sec, dat;
  logic          tz;
  logic [AW-1:0] ptr;

  wire cmd_wr  = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire is_rd   = (cmd == 8'h80) | (cmd == 8'h90);
  wire is_wrc  = (cmd == 8'hA0) | (cmd == 8'hA2);
  wire in_exec = (phase == PH_EXEC);
  wire dat_rd  = bus_sel & ~bus_wr & (bus_addr == 2'd3);
  wire dat_wr  = bus_sel &  bus_wr & (bus_addr == 2'd3);
  wire rd_xfer = dat_rd & in_exec & is_rd;
  wire wr_xfer = dat_wr & in_exec & is_wrc;

  wire [31:0] lin = ((32'(trk) * SIDES + 32'(side)) * SECS + 32'(sec) - 32'd1) * SEC_BYTES;
  wire [AW-1:0] sect_addr = lin[AW-1:0];

  wire [7:0] status = {1'b1, 4'b0, tz, in_exec & (is_rd | is_wrc), in_exec};

  assign mem_addr  = ptr;
  assign mem_wdata = bus_wdata;
  assign mem_we    = wr_xfer;
  assign mem_re    = rd_xfer;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = status;
      2'd1:    bus_rdata = trk;
      2'd2:    bus_rdata = sec;
      default: bus_rdata = rd_xfer ? mem_rdata : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      cmd   <= '0;
      trk   <= '0;
      sec   <= '0;
      dat   <= '0;
      tz    <= 1'b0;
      ptr   <= '0;
      err   <= 1'b0;
    end else if (cmd_wr) begin
      cmd   <= bus_wdata;
      phase <= PH_PREP;
      cnt   <= CW'(LAT);
      case (bus_wdata)
        8'h00: begin trk <= '0; tz <= 1'b1; end
        8'h10, 8'h14: begin trk <= dat; tz <= (dat == 8'h00); end
        8'h80, 8'h90, 8'hA0, 8'hA2: begin ptr <= sect_addr; tz <= 1'b0; end
        8'hD0: begin phase <= PH_IDLE; cmd <= '0; cnt <= '0; tz <= 1'b0; end
        8'hF0: begin tz <= 1'b0; err <= 1'b1; end
        default: ;
      endcase
    end else begin
      case (phase)
        PH_PREP: begin
          if (cnt == CW'(1)) begin
            phase <= PH_EXEC;
            cnt   <= CW'(EXE);
          end else
            cnt <= cnt - CW'(1);
        end
        PH_EXEC: begin
          if (cnt == CW'(1)) phase <= PH_IDLE;
          cnt <= cnt - CW'(1);
        end
        default: ;
      endcase
      if (rd_xfer | wr_xfer) begin
        ptr   <= ptr + AW'(1);
        cnt   <= CW'(EXE);
        phase <= PH_EXEC;
      end
      if (bus_sel & bus_wr & (bus_addr == 2'd1)) trk <= bus_wdata;
      if (bus_sel & bus_wr & (bus_addr == 2'd2)) sec <= bus_wdata;
      if (dat_wr & ~wr_xfer) dat <= bus_wdata;
      if (dat_rd & ~rd_xfer) err <= 1'b1;
    end
  end

  assert_prep_end_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PREP && cnt == CW'(1) && !cmd_wr) |=> (phase == PH_EXEC && cnt == CW'(EXE)));

  assert_restore_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == 8'h00) |=> (trk == 8'h00 && tz));

  assert_seek_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (bus_wdata == 8'h10 || bus_wdata == 8'h14)) |=> (trk == $past(dat)));

  assert_read_step_R7: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (ptr == $past(ptr) + AW'(1) && cnt == CW'(EXE) && phase == PH_EXEC));

  assert_write_step_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (ptr == $past(ptr) + AW'(1) && cnt == CW'(EXE) && phase == PH_EXEC));

  assert_force_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == 8'hD0) |=> (phase == PH_IDLE && !tz));

  assert_format_err_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata == 8'hF0) |=> err);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
endmodule

// File: tb/floppy_ctrl_test.sv
module floppy_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, side = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;
  logic        mem_we, mem_re, err;

  logic [7:0] mem [0:4095];

  int checks = 0, errors = 0;

  int m_ph, m_cnt, m_trk, m_sec, m_dat, m_tz, m_err, m_cmd;
  logic [19:0] m_ptr;

  always #5 clk = ~clk;

  floppy_ctrl uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .side(side), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .err(err)
  );

  assign mem_rdata = mem[mem_addr[11:0]];

  initial for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));

  always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

  function automatic bit is_rd(int c);
    return c == 8'h80 || c == 8'h90;
  endfunction
  function automatic bit is_wc(int c);
    return c == 8'hA0 || c == 8'hA2;
  endfunction

  // Reference model, advanced on each rising edge
  always @(posedge clk) begin
    bit rx, wx;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_trk = 0; m_sec = 0; m_dat = 0;
      m_tz = 0; m_err = 0; m_cmd = 0; m_ptr = '0;
    end else if (bus_sel && bus_wr && bus_addr == 0) begin
      m_cmd = bus_wdata; m_ph = 1; m_cnt = 10;
      case (bus_wdata)
        8'h00: begin m_trk = 0; m_tz = 1; end
        8'h10, 8'h14: begin m_trk = m_dat; m_tz = (m_dat == 0); end
        8'h80, 8'h90, 8'hA0, 8'hA2: begin
          m_ptr = 20'(((m_trk * 2 + side) * 9 + m_sec - 1) * 512);
          m_tz = 0;
        end
        8'hD0: begin m_ph = 0; m_cmd = 0; m_cnt = 0; m_tz = 0; end
        8'hF0: begin m_tz = 0; m_err = 1; end
        default: ;
      endcase
    end else begin
      rx = bus_sel && !bus_wr && bus_addr == 3 && m_ph == 2 && is_rd(m_cmd);
      wx = bus_sel &&  bus_wr && bus_addr == 3 && m_ph == 2 && is_wc(m_cmd);
      if (m_ph == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin m_ph = 2; m_cnt = 10; end
      end else if (m_ph == 2) begin
        m_cnt--;
        if (m_cnt == 0) m_ph = 0;
      end
      if (rx || wx) begin m_ptr = m_ptr + 20'd1; m_cnt = 10; m_ph = 2; end
      if (bus_sel && bus_wr && bus_addr == 1) m_trk = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 2) m_sec = bus_wdata;
      if (bus_sel && bus_wr && bus_addr == 3 && !wx) m_dat = bus_wdata;
      if (bus_sel && !bus_wr && bus_addr == 3 && !rx) m_err = 1;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit s, input bit w, input logic [1:0] a, input logic [7:0] d, input string tag);
    bit rx, wx;
    int exp;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    rx = s && !w && a == 3 && m_ph == 2 && is_rd(m_cmd);
    wx = s &&  w && a == 3 && m_ph == 2 && is_wc(m_cmd);
    check(32'(mem_re), 32'(rx), "R7 mem_re");
    check(32'(mem_we), 32'(wx), "R8 R10 mem_we");
    if (rx || wx) check(32'(mem_addr), 32'(m_ptr), "R6 mem_addr");
    if (wx) check(32'(mem_wdata), 32'(d), "R8 mem_wdata");
    check(32'(err), m_err, "R10 R11 err");
    if (s && !w) begin
      case (a)
        2'd0: exp = 8'h80 | (m_tz << 2) | ((m_ph == 2 && (is_rd(m_cmd) || is_wc(m_cmd))) << 1) | (m_ph == 2);
        2'd1: exp = m_trk;
        2'd2: exp = m_sec;
        default: exp = rx ? 32'(mem[m_ptr[11:0]]) : 0;
      endcase
      check(32'(bus_rdata), exp, tag);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rreg(input logic [1:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 8'h00, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) rreg(2'd0, "R2 R3 status");
  endtask
  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; bus_sel = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rreg(2'd0, "R1 status"); rreg(2'd1, "R1 track"); rreg(2'd2, "R1 sector");
    // R12 track and sector registers
    wreg(2'd1, 8'h05, "R12"); wreg(2'd2, 8'h03, "R12");
    rreg(2'd1, "R12 track"); rreg(2'd2, "R12 sector");
    // R4 restore
    wreg(2'd0, 8'h00, "R4"); idle(22); rreg(2'd1, "R4 track");
    // R5 seek to nonzero, then seek with verify to zero
    wreg(2'd3, 8'h07, "R8 latch"); wreg(2'd0, 8'h10, "R5"); idle(21); rreg(2'd1, "R5 track");
    wreg(2'd3, 8'h00, "R8 latch"); wreg(2'd0, 8'h14, "R5"); idle(3);
    rreg(2'd0, "R5 status"); rreg(2'd1, "R5 track"); idle(18);
    // R6 R7 read on side 1, with a read on the final execution clock
    side = 1'b1;
    wreg(2'd1, 8'h01, "R12"); wreg(2'd2, 8'h02, "R12"); wreg(2'd0, 8'h80, "R6");
    idle(10);
    for (int k = 0; k < 3; k++) rreg(2'd3, "R7 data");
    idle(9); rreg(2'd3, "R7 last-tick reload"); idle(12);
    // R8 write sector at track 0 side 0 sector 1
    side = 1'b0;
    wreg(2'd1, 8'h00, "R12"); wreg(2'd2, 8'h01, "R12"); wreg(2'd0, 8'hA2, "R8");
    idle(10);
    for (int k = 0; k < 4; k++) wreg(2'd3, 8'(8'hC0 + k), "R8 store");
    idle(11);
    wreg(2'd0, 8'hA0, "R8"); idle(10);
    wreg(2'd3, 8'h55, "R8 store"); wreg(2'd3, 8'hAA, "R8 store"); idle(11);
    // R7 read back with multi-sector read; data write in read execution latches
    wreg(2'd0, 8'h90, "R7"); idle(10);
    for (int k = 0; k < 6; k++) rreg(2'd3, "R7 readback");
    idle(2); wreg(2'd3, 8'h21, "R8 latch in read"); idle(12);
    wreg(2'd0, 8'h10, "R5"); idle(2); rreg(2'd1, "R5 track from latch"); idle(19);
    // R9 force interrupt during execution
    wreg(2'd1, 8'h00, "R12");
    wreg(2'd0, 8'h80, "R9"); idle(12);
    wreg(2'd0, 8'hD0, "R9"); rreg(2'd0, "R9 status idle"); idle(3);
    // R11 data read outside read execution
    rreg(2'd3, "R11 data idle"); idle(3);
    // R10 write track after reset
    do_reset;
    rreg(2'd0, "R1 status"); rreg(2'd1, "R1 track");
    wreg(2'd0, 8'hF0, "R10"); rreg(2'd0, "R10 status"); idle(12);
    wreg(2'd3, 8'h44, "R10 no store"); idle(10);
    // R11 data read during preparation phase
    do_reset;
    wreg(2'd2, 8'h01, "R12"); wreg(2'd0, 8'h80, "R11"); idle(3);
    rreg(2'd3, "R11 data in prep"); idle(20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule